// File: doc/BRIEF.md
# Dual-Level Bus Cycle Watchdog

This block follows each system bus cycle from its start strobe until the cycle ends. A cycle ends on a normal acknowledge, on an error from an outside source, or on a timeout raised by the block itself. Two counters run side by side. The short local counter ends a stalled cycle with a bus-error pulse. It is held off when the address decode marks the cycle as an expansion-bus access, because the expansion-bus controller applies its own longer limit to those accesses. The long global counter runs for every cycle, expansion-bus cycles included. It ends any access that neither the local counter nor the expansion controller ended, such as a slot card that stays silent for part of its decoded space.

All periods are given in clock cycles. The global period must be strictly greater than the local period and greater than the expansion controller's period (`EXP_TICKS`). The block carries no data stream, so all of its pins are plain control and status pins with no handshake. A two-bit status output keeps the source of the most recent timeout.

Top module: `bus_cycle_watchdog`

## Requirements
- R1: After reset, `berr_o` is 0 and `last_src_o` is 2'b00 (no timeout seen).
- R2: For a cycle with `cyc_exp`=0 that gets no response, `berr_o` is high in exactly the clock that comes LOCAL_TICKS clocks after the clock in which `cyc_start` was high. `last_src_o` then becomes 2'b01 (local).
- R3: For a cycle with `cyc_exp`=1, the local counter never fires. With no response, `berr_o` rises GLOBAL_TICKS clocks after the start clock and `last_src_o` becomes 2'b10 (global).
- R4: A `cyc_ack` before the timeout clock ends the cycle, and no `berr_o` follows.
- R5: A `cyc_err_in` before the timeout clock ends the cycle in the same way, with no `berr_o`.
- R6: If `cyc_ack` or `cyc_err_in` arrives in the timeout clock itself, the response wins: `berr_o` stays low and `last_src_o` is unchanged.
- R7: A `cyc_start` while a cycle is in flight ends the old cycle without an error. Both counters then restart from the new start, using the new `cyc_exp` value.
- R8: `berr_o` is never high for two clocks in a row. It is never high while no cycle is in flight.
- R9: `last_src_o` changes only in the clock after a `berr_o` pulse. Otherwise it holds its value, and responses and idle time leave it unchanged.
- R10: An expansion-bus cycle acknowledged later than LOCAL_TICKS clocks, but before GLOBAL_TICKS, ends with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock strobe that opens a bus cycle |
| cyc_exp | input | 1 | Region decode, valid with `cyc_start`; 1 = expansion-bus target |
| cyc_ack | input | 1 | Normal acknowledge for the cycle in flight |
| cyc_err_in | input | 1 | Error termination from another source |
| berr_o | output | 1 | One-clock bus-error strobe on timeout |
| last_src_o | output | 2 | Source of the most recent timeout: 00 none, 01 local, 10 global |

## Verification
The main function is driven with a set of cycles that cover both decode values and three kinds of ending: silence, acknowledge and external error. Each response is placed before, on, or after the timeout clock. A silent normal cycle and a silent expansion cycle show that the two counters are chosen by the decode. An expansion acknowledge arriving after the local period shows that the local counter is held off. Responses placed exactly on the timeout clock separate "response wins" from "error wins". A restart in the middle of a cycle, with the other decode value, shows that the counters reload and that the decode is latched again.

// File: rtl/bcw_pkg.sv
package bcw_pkg;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'b00,
    SRC_LOCAL  = 2'b01,
    SRC_GLOBAL = 2'b10
  } fire_src_e;

endpackage

// File: rtl/bcw_tracker.sv
// Holds whether a cycle is in flight and the region decode taken at its start.
module bcw_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic exp_i,
  input  logic done_i,
  output logic busy_o,
  output logic exp_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      exp_o  <= 1'b0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      exp_o  <= exp_i;
    end else if (done_i) begin
      busy_o <= 1'b0;
    end
  end

  // R7: a start always leaves a cycle in flight on the next clock
  a_r7_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);

endmodule

// File: rtl/bcw_timer.sv
// Counts clocks while enabled and reports expiry in the LIMIT-th enabled clock.
module bcw_timer #(
  parameter int LIMIT = 12,
  parameter int W     = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  input  logic stop_i,
  output logic expire_o
);

  logic [W-1:0] cnt;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clear_i)           cnt <= '0;
    else if (stop_i || !run_i)  cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  assign expire_o = run_i && (cnt == LAST);

  // R8: the count never runs past its limit
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/bcw_status.sv
// Remembers which counter produced the latest timeout.
module bcw_status
  import bcw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fire_i,
  input  logic      global_i,
  output fire_src_e src_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)      src_o <= SRC_NONE;
    else if (fire_i) src_o <= global_i ? SRC_GLOBAL : SRC_LOCAL;
  end

  // R9: without a timeout pulse the status holds
  a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> $stable(src_o));

endmodule

// File: rtl/bus_cycle_watchdog.sv
module bus_cycle_watchdog
  import bcw_pkg::*;
#(
  parameter int LOCAL_TICKS  = 12,
  parameter int EXP_TICKS    = 20,
  parameter int GLOBAL_TICKS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_start,
  input  logic       cyc_exp,
  input  logic       cyc_ack,
  input  logic       cyc_err_in,
  output logic       berr_o,
  output logic [1:0] last_src_o
);

  localparam int CNT_W = $clog2(GLOBAL_TICKS + 1);

  logic busy, exp_q;
  logic loc_exp, glb_exp;
  logic responded, done;
  fire_src_e src;

  assign responded = cyc_ack || cyc_err_in;
  assign berr_o    = busy && (loc_exp || glb_exp) && !responded && !cyc_start;
  assign done      = responded || berr_o;

  bcw_tracker u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (cyc_start),
    .exp_i   (cyc_exp),
    .done_i  (done),
    .busy_o  (busy),
    .exp_o   (exp_q)
  );

  bcw_timer #(.LIMIT(LOCAL_TICKS), .W(CNT_W)) u_local (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (cyc_start),
    .run_i    (busy && !exp_q),
    .stop_i   (done),
    .expire_o (loc_exp)
  );

  bcw_timer #(.LIMIT(GLOBAL_TICKS), .W(CNT_W)) u_global (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (cyc_start),
    .run_i    (busy),
    .stop_i   (done),
    .expire_o (glb_exp)
  );

  bcw_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (berr_o),
    .global_i (glb_exp),
    .src_o    (src)
  );

  assign last_src_o = src;

  // R8: the error strobe lasts one clock
  a_r8_berr_single: assert property (@(posedge clk) disable iff (!rst_n)
    berr_o |=> !berr_o);

  // R3: the local counter stays silent for expansion-bus cycles
  a_r3_local_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && exp_q) |-> !loc_exp);

  // R4: an acknowledge closes the cycle, so no error follows
  a_r4_ack_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ack && !cyc_start) |=> !berr_o);

  // R5: an outside error closes the cycle, so no error follows
  a_r5_err_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_err_in && !cyc_start) |=> !berr_o);

endmodule

// File: tb/bus_cycle_watchdog_bench.sv
module bus_cycle_watchdog_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LT = 12;
  localparam int ET = 20;
  localparam int GT = 32;

  typedef struct packed {
    logic       exp;
    logic [1:0] kind;   // 0 silent, 1 ack, 2 outside error
    logic [7:0] at;     // clock index of the response after the start clock
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 8'd0},
    '{1'b0, 2'd1, 8'd3},
    '{1'b0, 2'd1, 8'd12},
    '{1'b0, 2'd2, 8'd5},
    '{1'b1, 2'd0, 8'd0},
    '{1'b1, 2'd1, 8'd20},
    '{1'b0, 2'd1, 8'd13},
    '{1'b1, 2'd2, 8'd32},
    '{1'b1, 2'd1, 8'd31}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0, cyc_exp = 1'b0, cyc_ack = 1'b0, cyc_err_in = 1'b0;
  logic berr_o;
  logic [1:0] last_src_o;

  int total = 0;
  int bad = 0;
  logic [1:0] want_src = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_watchdog #(.LOCAL_TICKS(LT), .EXP_TICKS(ET), .GLOBAL_TICKS(GT)) u_bus_cycle_watchdog (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_exp(cyc_exp),
    .cyc_ack(cyc_ack), .cyc_err_in(cyc_err_in),
    .berr_o(berr_o), .last_src_o(last_src_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Runs one cycle; returns the first error clock (-1 if none) and pulse count.
  task automatic run_cycle(input logic exp, input int kind, input int at,
                           output int first, output int pulses);
    first = -1;
    pulses = 0;
    @(negedge clk);
    cyc_start = 1'b1; cyc_exp = exp;
    #1;
    if (berr_o) pulses++;
    @(negedge clk);
    cyc_start = 1'b0; cyc_exp = 1'b0;
    for (int c = 1; c <= GT + 4; c++) begin
      cyc_ack    = (kind == 1 && c == at);
      cyc_err_in = (kind == 2 && c == at);
      #1;
      if (berr_o) begin
        pulses++;
        if (first < 0) first = c;
      end
      @(negedge clk);
      cyc_ack = 1'b0; cyc_err_in = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first, pulses, tmo, want_first;
    repeat (3) @(negedge clk);
    #1;
    check(berr_o == 1'b0, "R1 berr after reset", berr_o, 0);
    check(last_src_o == 2'b00, "R1 status after reset", last_src_o, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      tmo = VECS[i].exp ? GT : LT;
      if (VECS[i].kind != 0 && int'(VECS[i].at) <= tmo) want_first = -1;
      else want_first = tmo;
      run_cycle(VECS[i].exp, int'(VECS[i].kind), int'(VECS[i].at), first, pulses);
      if (want_first >= 0) want_src = VECS[i].exp ? 2'b10 : 2'b01;
      // R2 R3 R4 R5 R6 R10 timing of the error strobe
      check(first == want_first, $sformatf("R2/R3/R4/R5/R6/R10 vec%0d error clock", i), first, want_first);
      check(pulses == (want_first >= 0 ? 1 : 0), $sformatf("R8 vec%0d pulse count", i), pulses, want_first >= 0 ? 1 : 0);
      check(last_src_o == want_src, $sformatf("R9 vec%0d status", i), last_src_o, want_src);
    end

    // R7: restart at clock 5 of a normal cycle with expansion decode
    @(negedge clk);
    cyc_start = 1'b1; cyc_exp = 1'b0;
    @(negedge clk);
    cyc_start = 1'b0;
    repeat (4) @(negedge clk);
    begin
      first = -1;
      pulses = 0;
      cyc_start = 1'b1; cyc_exp = 1'b1;
      #1;
      if (berr_o) pulses++;
      @(negedge clk);
      cyc_start = 1'b0; cyc_exp = 1'b0;
      for (int c = 1; c <= GT + 3; c++) begin
        #1;
        if (berr_o) begin
          pulses++;
          if (first < 0) first = c;
        end
        @(negedge clk);
      end
    end
    check(first == GT, "R7 restart reloads with new decode", first, GT);
    check(pulses == 1, "R7 single pulse after restart", pulses, 1);
    check(last_src_o == 2'b10, "R7 status global", last_src_o, 2);

    // R8: idle line stays quiet
    pulses = 0;
    for (int c = 0; c < 40; c++) begin
      #1;
      if (berr_o) pulses++;
      @(negedge clk);
    end
    check(pulses == 0, "R8 no error while idle", pulses, 0);

    // R9: stray ack and error while idle leave status alone
    cyc_ack = 1'b1; cyc_err_in = 1'b1;
    @(negedge clk);
    cyc_ack = 1'b0; cyc_err_in = 1'b0;
    @(negedge clk);
    #1;
    check(last_src_o == 2'b10, "R9 status holds on idle responses", last_src_o, 2);
    check(berr_o == 1'b0, "R9 no error on idle responses", berr_o, 0);

    // R1: reset again clears status
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    check(last_src_o == 2'b00, "R1 status cleared by reset", last_src_o, 0);
    check(berr_o == 1'b0, "R1 berr low in reset", berr_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule